// File: doc/BRIEF.md
# Interrupt Stack Frame Engine

This block saves and restores the processor state around an interrupt for a core that widens an 8-bit legacy instruction set to a larger address space. It supports two frame layouts. The short layout holds a status byte and a 16-bit return address, as legacy software expects. The long layout adds an extended status byte and a return address as wide as the core. Bit 5 of the stacked status byte marks the layout, and the engine reads that bit when it pulls a frame. The engine owns the stack pointer and moves one byte per cycle over a byte-wide stack memory port.

The core issues one of three requests: interrupt entry, which pushes a frame; return from interrupt, which pulls a whole frame; and status pull, which restores only the status bytes. While an operation runs, `busy` is high and other requests have no effect. One cycle after the last byte, a single-cycle `done` pulse marks that the restored status, the extended status and the return address are valid. Decoding instructions, choosing vectors and arithmetic are handled elsewhere in the core.

Top module: `irq_stack_frame_engine`

## Requirements
- R1: After reset, `sp` equals SP_RESET (default 16'h01FF), and `busy`, `done` and `mem_we` are 0. The restored status, extended status and address outputs are all 0.
- R2: `req_op` encodes 01 = push, 10 = return from interrupt, 11 = status pull, and 00 = no operation, which is ignored. A request is accepted on a clock edge where `busy` is low and `req_valid` is high. `busy` is then high for exactly L cycles for an L-byte frame, and `done` is high for the one cycle that follows, with `busy` low.
- R3: While `busy` is high, `req_valid` and the push data inputs have no effect on the operation that is running.
- R4: A push writes each byte at `sp` and then decrements `sp`. The return address goes most significant byte first. After an L-byte push, `sp` is the starting value minus L.
- R5: When `compat_mode` is 1, a push builds the 3-byte short frame. Relative to the final `sp`, the status byte with bit 5 forced to 1 is at +1, address byte 0 is at +2 and address byte 1 is at +3.
- R6: When `compat_mode` is 0, a push builds the long frame. The status byte with bit 5 forced to 0 is at +1, the extended status byte is at +2, and the return address bytes start at +3 and go upward from byte 0. There are ADDR_BYTES address bytes (default 8, which places them at +3 to +10).
- R7: A return from interrupt first reads the status byte at `sp`+1. If bit 5 of that byte is 1, the engine pulls 3 bytes in total. The restored address takes its low 16 bits from the stack and its upper bits from `cur_pc` as sampled when the request was accepted. The restored extended status is 0.
- R8: If bit 5 of the first byte is 0, a return from interrupt also pulls the extended status byte and then the return address bytes, low byte first.
- R9: A status pull reads 1 byte when bit 5 of that byte is 1, or 2 bytes when it is 0; the second byte is the extended status. A status pull leaves `rest_addr` unchanged.
- R10: The extended status keeps only bit 0 (G) and bit 1 (OE). All other bits are 0, both when the byte is pushed and when it is restored.
- R11: When `narrow_mode` is 1, a long frame holds 2 address bytes, both on push and on pull. The upper bits of the restored address come from `cur_pc`.
- R12: A pull increments `sp` before each read. After an L-byte pull, `sp` is the starting value plus L.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | Operation code (see R2) |
| compat_mode | input | 1 | 1 = push the short legacy frame |
| narrow_mode | input | 1 | 1 = 16-bit effective address width |
| push_status | input | 8 | Status byte to push |
| push_xstatus | input | 8 | Extended status byte to push |
| push_addr | input | 8*ADDR_BYTES | Return address to push |
| cur_pc | input | 8*ADDR_BYTES | Current program counter, supplies the upper address bits |
| mem_we | output | 1 | Stack memory write enable |
| mem_addr | output | SPW | Stack memory byte address |
| mem_wdata | output | 8 | Stack memory write data |
| mem_rdata | input | 8 | Stack memory read data, valid in the same cycle |
| busy | output | 1 | High during each byte transfer |
| done | output | 1 | One-cycle completion pulse |
| sp | output | SPW | Stack pointer |
| rest_status | output | 8 | Restored status byte |
| rest_xstatus | output | 8 | Restored extended status |
| rest_addr | output | 8*ADDR_BYTES | Restored return address |

## Verification
The hardest case to reach is a pull whose layout contradicts the way the frame was pushed. An example is a frame written by software with bit 5 cleared, which makes the engine read an extended status byte and a full-width address from whatever sits above it. The bench creates these frames by writing its memory model directly, and it also runs status pulls over the same kind of bytes. Random nested pushes, with the short layout, the long layout and narrow mode mixed, are then unwound in reverse order. This checks that `sp` stays balanced and that each return picks up the high address bits from a fresh `cur_pc`.

// File: rtl/isf_pkg.sv
package isf_pkg;
    typedef enum logic [1:0] {
        OP_NONE = 2'b00,
        OP_PUSH = 2'b01,
        OP_RTI  = 2'b10,
        OP_PLP  = 2'b11
    } isf_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PUSH = 2'd1,
        ST_PULL = 2'd2
    } isf_state_e;

    // status bit whose clear value marks a long frame
    localparam int FRAME_SEL_BIT = 5;
    // user-visible extended flags: bit0 G, bit1 OE
    localparam logic [7:0] XS_KEEP = 8'h03;
endpackage

// File: rtl/isf_push_mux.sv
module isf_push_mux
    import isf_pkg::*;
#(
    parameter int ADDR_BYTES = 8,
    parameter int IW = 4
) (
    input  logic [IW-1:0]           idx,
    input  logic                    ext,
    input  logic                    narrow,
    input  logic [7:0]              stat,
    input  logic [7:0]              xs,
    input  logic [8*ADDR_BYTES-1:0] addr,
    output logic [7:0]              wbyte
);
    logic [IW-1:0] nb;
    logic [IW-1:0] pos;

    always_comb begin
        nb    = (ext && !narrow) ? IW'(ADDR_BYTES) : IW'(2);
        pos   = nb - idx - 1'b1;
        wbyte = stat;
        if (idx < nb) begin
            // address goes out most significant byte first
            for (int b = 0; b < ADDR_BYTES; b++) begin
                if (IW'(b) == pos) wbyte = addr[8*b +: 8];
            end
        end else if (ext && idx == nb) begin
            wbyte = xs & XS_KEEP;
        end
    end
endmodule

// File: rtl/isf_pull_merge.sv
module isf_pull_merge
    import isf_pkg::*;
#(
    parameter int ADDR_BYTES = 8,
    parameter int IW = 4
) (
    input  logic                    is_rti,
    input  logic [IW-1:0]           idx,
    input  logic [7:0]              rdata,
    input  logic                    ext_q,
    input  logic                    narrow,
    input  logic [7:0]              stat_q,
    input  logic [7:0]              xs_q,
    input  logic [8*ADDR_BYTES-1:0] addr_q,
    input  logic [IW-1:0]           len_q,
    output logic [7:0]              stat_n,
    output logic [7:0]              xs_n,
    output logic [8*ADDR_BYTES-1:0] addr_n,
    output logic [IW-1:0]           len_n,
    output logic                    ext_n
);
    logic [IW-1:0] nb;
    logic [IW-1:0] pos;

    always_comb begin
        stat_n = stat_q;
        xs_n   = xs_q;
        addr_n = addr_q;
        len_n  = len_q;
        ext_n  = ext_q;
        nb     = narrow ? IW'(2) : IW'(ADDR_BYTES);
        pos    = ext_q ? (idx - IW'(2)) : (idx - IW'(1));
        if (idx == '0) begin
            // first byte decides the layout of the rest
            stat_n = rdata;
            ext_n  = ~rdata[FRAME_SEL_BIT];
            xs_n   = 8'h00;
            if (is_rti) len_n = ext_n ? (nb + IW'(2)) : IW'(3);
            else        len_n = ext_n ? IW'(2) : IW'(1);
        end else if (ext_q && idx == IW'(1)) begin
            xs_n = rdata & XS_KEEP;
        end else begin
            for (int b = 0; b < ADDR_BYTES; b++) begin
                if (IW'(b) == pos) addr_n[8*b +: 8] = rdata;
            end
        end
    end
endmodule

// File: rtl/irq_stack_frame_engine.sv
module irq_stack_frame_engine
    import isf_pkg::*;
#(
    parameter int ADDR_BYTES = 8,
    parameter int SPW = 16,
    parameter logic [SPW-1:0] SP_RESET = 16'h01FF
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic [1:0]              req_op,
    input  logic                    compat_mode,
    input  logic                    narrow_mode,
    input  logic [7:0]              push_status,
    input  logic [7:0]              push_xstatus,
    input  logic [8*ADDR_BYTES-1:0] push_addr,
    input  logic [8*ADDR_BYTES-1:0] cur_pc,
    output logic                    mem_we,
    output logic [SPW-1:0]          mem_addr,
    output logic [7:0]              mem_wdata,
    input  logic [7:0]              mem_rdata,
    output logic                    busy,
    output logic                    done,
    output logic [SPW-1:0]          sp,
    output logic [7:0]              rest_status,
    output logic [7:0]              rest_xstatus,
    output logic [8*ADDR_BYTES-1:0] rest_addr
);
    localparam int AW = 8 * ADDR_BYTES;
    localparam int IW = $clog2(ADDR_BYTES + 3);

    typedef struct packed {
        isf_state_e     state;
        isf_op_e        op;
        logic           ext;
        logic           narrow;
        logic [IW-1:0]  idx;
        logic [IW-1:0]  len;
        logic [SPW-1:0] sp;
        logic           done;
        logic [7:0]     wstat;
        logic [7:0]     wxs;
        logic [AW-1:0]  waddr;
        logic [7:0]     rstat;
        logic [7:0]     rxs;
        logic [AW-1:0]  raddr;
    } regs_t;

    regs_t q, d;

    logic [7:0]    push_byte;
    logic [7:0]    m_stat;
    logic [7:0]    m_xs;
    logic [AW-1:0] m_addr;
    logic [IW-1:0] m_len;
    logic          m_ext;
    isf_op_e       op_in;

    assign op_in = isf_op_e'(req_op);

    isf_push_mux #(.ADDR_BYTES(ADDR_BYTES), .IW(IW)) u_push_mux (
        .idx   (q.idx),
        .ext   (q.ext),
        .narrow(q.narrow),
        .stat  (q.wstat),
        .xs    (q.wxs),
        .addr  (q.waddr),
        .wbyte (push_byte)
    );

    isf_pull_merge #(.ADDR_BYTES(ADDR_BYTES), .IW(IW)) u_pull_merge (
        .is_rti(q.op == OP_RTI),
        .idx   (q.idx),
        .rdata (mem_rdata),
        .ext_q (q.ext),
        .narrow(q.narrow),
        .stat_q(q.rstat),
        .xs_q  (q.rxs),
        .addr_q(q.raddr),
        .len_q (q.len),
        .stat_n(m_stat),
        .xs_n  (m_xs),
        .addr_n(m_addr),
        .len_n (m_len),
        .ext_n (m_ext)
    );

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = q.sp;
        mem_wdata = push_byte;
        unique case (q.state)
            ST_IDLE: begin
                if (req_valid && op_in != OP_NONE) begin
                    d.op     = op_in;
                    d.idx    = '0;
                    d.narrow = narrow_mode;
                    if (op_in == OP_PUSH) begin
                        d.state = ST_PUSH;
                        d.ext   = ~compat_mode;
                        d.wstat = compat_mode ? (push_status | 8'h20) : (push_status & 8'hDF);
                        d.wxs   = push_xstatus;
                        d.waddr = push_addr;
                        if (compat_mode)      d.len = IW'(3);
                        else if (narrow_mode) d.len = IW'(4);
                        else                  d.len = IW'(ADDR_BYTES + 2);
                    end else begin
                        d.state = ST_PULL;
                        d.len   = IW'(1);
                        if (op_in == OP_RTI) d.raddr = cur_pc;
                    end
                end
            end
            ST_PUSH: begin
                mem_we = 1'b1;
                d.sp   = q.sp - 1'b1;
                d.idx  = q.idx + 1'b1;
                if (q.idx == q.len - 1'b1) begin
                    d.state = ST_IDLE;
                    d.done  = 1'b1;
                end
            end
            ST_PULL: begin
                mem_addr = q.sp + 1'b1;
                d.sp     = q.sp + 1'b1;
                d.idx    = q.idx + 1'b1;
                d.rstat  = m_stat;
                d.rxs    = m_xs;
                d.raddr  = m_addr;
                d.len    = m_len;
                d.ext    = m_ext;
                if (q.idx == m_len - 1'b1) begin
                    d.state = ST_IDLE;
                    d.done  = 1'b1;
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            q.sp <= SP_RESET;
        end else begin
            q <= d;
        end
    end

    assign busy         = (q.state != ST_IDLE);
    assign done         = q.done;
    assign sp           = q.sp;
    assign rest_status  = q.rstat;
    assign rest_xstatus = q.rxs;
    assign rest_addr    = q.raddr;

    // R4: writes land at the current pointer, which then steps down
    p_write_at_sp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_addr == sp);
    p_sp_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> sp == $past(sp) - 1'b1);
    // R12: every pull cycle moves the pointer up by one
    p_sp_inc_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mem_we) |=> sp == $past(sp) + 1'b1);
    // R2: done is a single pulse outside the busy window
    p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !mem_we));
    // R10: only G and OE survive in the restored extended status
    p_xs_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (rest_xstatus & ~XS_KEEP) == 8'h00);
endmodule

// File: tb/test_irq_stack_frame_engine.sv
module test_irq_stack_frame_engine;
    localparam int AB = 8;
    localparam int AW = 8 * AB;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          req_valid;
    logic [1:0]    req_op;
    logic          compat_mode, narrow_mode;
    logic [7:0]    push_status, push_xstatus;
    logic [AW-1:0] push_addr, cur_pc;
    logic          mem_we;
    logic [15:0]   mem_addr;
    logic [7:0]    mem_wdata, mem_rdata;
    logic          busy, done;
    logic [15:0]   sp;
    logic [7:0]    rest_status, rest_xstatus;
    logic [AW-1:0] rest_addr;

    logic [7:0] mem [0:65535];

    always #10 clk = ~clk;

    assign mem_rdata = mem[mem_addr];
    always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

    irq_stack_frame_engine #(.ADDR_BYTES(AB)) i_irq_stack_frame_engine (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .compat_mode(compat_mode), .narrow_mode(narrow_mode),
        .push_status(push_status), .push_xstatus(push_xstatus),
        .push_addr(push_addr), .cur_pc(cur_pc),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .busy(busy), .done(done), .sp(sp),
        .rest_status(rest_status), .rest_xstatus(rest_xstatus),
        .rest_addr(rest_addr)
    );

    int nchk = 0;
    int nfail = 0;
    bit finished = 0;

    task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: got %h expected %h", rq, act, exp);
        end
    endtask

    function automatic int nbytes(input bit narrow);
        return narrow ? 2 : AB;
    endfunction

    function automatic int frame_len(input bit compat, input bit narrow);
        return compat ? 3 : nbytes(narrow) + 2;
    endfunction

    function automatic logic [7:0] frame_byte(input bit compat, input logic [7:0] st,
            input logic [7:0] xs, input logic [AW-1:0] a, input int k);
        if (k == 0) return compat ? (st | 8'h20) : (st & 8'hDF);
        if (!compat) begin
            if (k == 1) return xs & 8'h03;
            return 8'(a >> (8 * (k - 2)));
        end
        return 8'(a >> (8 * (k - 1)));
    endfunction

    task automatic run_op(input logic [1:0] op, input bit poke, output int cyc, output int bcnt);
        req_op = op;
        req_valid = 1'b1;
        cyc = 0;
        bcnt = 0;
        while (1) begin
            @(negedge clk);
            cyc++;
            req_valid = 1'b0;
            if (poke && cyc == 2) begin
                req_valid = 1'b1;
                req_op = 2'b10;
                push_status = ~push_status;
                push_addr = ~push_addr;
            end
            if (busy) bcnt++;
            if (done || cyc > 40) break;
        end
        req_valid = 1'b0;
    endtask

    task automatic do_push(input bit compat, input bit narrow, input logic [7:0] st,
            input logic [7:0] xs, input logic [AW-1:0] a, input bit poke);
        int cyc, bcnt, len;
        logic [15:0] s0;
        compat_mode = compat;
        narrow_mode = narrow;
        push_status = st;
        push_xstatus = xs;
        push_addr = a;
        s0 = sp;
        len = frame_len(compat, narrow);
        run_op(2'b01, poke, cyc, bcnt);
        chk("R2 push cycles to done", 64'(cyc), 64'(len + 1));
        chk("R2 push busy cycles", 64'(bcnt), 64'(len));
        chk("R4 sp after push", 64'(sp), 64'(s0 - 16'(len)));
        for (int k = 0; k < len; k++)
            chk(compat ? "R5 short frame byte" : "R6 long frame byte",
                64'(mem[16'(sp + 16'(k) + 16'd1)]), 64'(frame_byte(compat, st, xs, a, k)));
        if (poke) begin
            @(negedge clk);
            chk("R3 no extra op after poke", 64'(busy), 64'd0);
            chk("R3 sp held after poke", 64'(sp), 64'(s0 - 16'(len)));
        end
    endtask

    task automatic do_rti(input bit compat, input bit narrow, input logic [7:0] st,
            input logic [7:0] xs, input logic [AW-1:0] a);
        int cyc, bcnt, len;
        logic [15:0] s0;
        logic [AW-1:0] pc, ea;
        pc = {$urandom, $urandom};
        cur_pc = pc;
        narrow_mode = narrow;
        compat_mode = $urandom_range(1);
        s0 = sp;
        len = frame_len(compat, narrow);
        ea = (!compat && !narrow) ? a : {pc[AW-1:16], a[15:0]};
        run_op(2'b10, 1'b0, cyc, bcnt);
        cur_pc = ~pc;
        chk("R2 pull cycles to done", 64'(cyc), 64'(len + 1));
        chk("R12 sp after pull", 64'(sp), 64'(s0 + 16'(len)));
        chk(compat ? "R7 status" : "R8 status", 64'(rest_status), 64'(frame_byte(compat, st, xs, a, 0)));
        chk(compat ? "R7 xstatus zero" : "R10 xstatus", 64'(rest_xstatus), compat ? 64'd0 : 64'(xs & 8'h03));
        chk(compat ? "R7 address" : (narrow ? "R11 address" : "R8 address"), rest_addr, ea);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            nfail++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    bit          fr_c [4];
    bit          fr_n [4];
    logic [7:0]  fr_s [4];
    logic [7:0]  fr_x [4];
    logic [AW-1:0] fr_a [4];

    initial begin
        int cyc, bcnt;
        logic [15:0] s;
        logic [AW-1:0] keep;
        void'($urandom(32'd7));
        rst_n = 1'b0; req_valid = 1'b0; req_op = 2'b00;
        compat_mode = 1'b1; narrow_mode = 1'b0;
        push_status = 8'h00; push_xstatus = 8'h00;
        push_addr = '0; cur_pc = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 sp reset", 64'(sp), 64'h01FF);
        chk("R1 busy reset", 64'(busy), 64'd0);
        chk("R1 done reset", 64'(done), 64'd0);
        chk("R1 we reset", 64'(mem_we), 64'd0);
        chk("R1 outputs reset", {rest_status, rest_xstatus, rest_addr[47:0]}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: no-op code ignored
        req_valid = 1'b1; req_op = 2'b00;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R2 op none busy", 64'(busy), 64'd0);
        chk("R2 op none sp", 64'(sp), 64'h01FF);

        // R5 then R7: short frame round trip
        do_push(1'b1, 1'b0, 8'h81, 8'hFF, 64'h1122_3344_5566_A7B8, 1'b0);
        do_rti(1'b1, 1'b0, 8'h81, 8'hFF, 64'h1122_3344_5566_A7B8);
        // R6, R10 then R8
        do_push(1'b0, 1'b0, 8'hFF, 8'hFF, 64'h0102_0304_0506_0708, 1'b0);
        do_rti(1'b0, 1'b0, 8'hFF, 8'hFF, 64'h0102_0304_0506_0708);
        // R11 narrow long frame
        do_push(1'b0, 1'b1, 8'h3C, 8'h02, 64'hDEAD_BEEF_CAFE_1234, 1'b0);
        do_rti(1'b0, 1'b1, 8'h3C, 8'h02, 64'hDEAD_BEEF_CAFE_1234);
        // R3 request and data changes while busy
        do_push(1'b0, 1'b0, 8'h55, 8'h01, 64'hA0A1_A2A3_A4A5_A6A7, 1'b1);
        do_rti(1'b0, 1'b0, 8'h55, 8'h01, 64'hA0A1_A2A3_A4A5_A6A7);

        // R8: hand-built frame with bit 5 cleared
        s = sp;
        mem[16'(s + 1)] = 8'h00;
        mem[16'(s + 2)] = 8'h81;
        for (int k = 0; k < AB; k++) mem[16'(s + 16'(k) + 3)] = 8'(8'hE0 + k);
        narrow_mode = 1'b0;
        run_op(2'b10, 1'b0, cyc, bcnt);
        chk("R8 crafted cycles", 64'(cyc), 64'(AB + 3));
        chk("R8 crafted address", rest_addr, 64'hE7E6_E5E4_E3E2_E1E0);
        chk("R10 crafted xstatus", 64'(rest_xstatus), 64'h01);
        keep = rest_addr;

        // R9: status pull over a long-frame status byte
        s = sp;
        mem[16'(s + 1)] = 8'h4C;
        mem[16'(s + 2)] = 8'hFE;
        run_op(2'b11, 1'b0, cyc, bcnt);
        chk("R9 pull two bytes cycles", 64'(cyc), 64'd3);
        chk("R9 status", 64'(rest_status), 64'h4C);
        chk("R10 pulled xstatus masked", 64'(rest_xstatus), 64'h02);
        chk("R12 sp after status pull", 64'(sp), 64'(s + 16'd2));
        chk("R9 address untouched", rest_addr, keep);
        // R9: short form
        s = sp;
        mem[16'(s + 1)] = 8'hA5;
        run_op(2'b11, 1'b0, cyc, bcnt);
        chk("R9 pull one byte cycles", 64'(cyc), 64'd2);
        chk("R9 short status", 64'(rest_status), 64'hA5);
        chk("R9 short xstatus zero", 64'(rest_xstatus), 64'h00);
        chk("R9 short address untouched", rest_addr, keep);
        chk("R12 sp after short pull", 64'(sp), 64'(s + 16'd1));

        // random nested frames unwound in reverse
        for (int r = 0; r < 30; r++) begin
            int depth;
            depth = 1 + $urandom_range(3);
            for (int k = 0; k < depth; k++) begin
                fr_c[k] = $urandom_range(1);
                fr_n[k] = $urandom_range(1);
                fr_s[k] = 8'($urandom);
                fr_x[k] = 8'($urandom);
                fr_a[k] = {$urandom, $urandom};
                do_push(fr_c[k], fr_n[k], fr_s[k], fr_x[k], fr_a[k], 1'b0);
            end
            for (int k = depth - 1; k >= 0; k--)
                do_rti(fr_c[k], fr_n[k], fr_s[k], fr_x[k], fr_a[k]);
        end

        finished = 1;
        summary();
        $finish;
    end
endmodule